// File: doc/BRIEF.md
# Dual-Edge Pin Event Detector with Wake Request

This block watches a bank of general-purpose input pins and turns their transitions into latched interrupt events and a wake request. Each pin is first brought into the local clock domain by a two-stage synchroniser. An edge is a difference between two consecutive synchronised samples. Rising and falling transitions are enabled independently per pin, so a pin can trigger on one edge, on both, or on none. Only edges are detected. There is no level trigger.

An enabled edge sets a sticky bit in the event status register, and the interrupt line is high whenever any status bit is set. Software clears bits by writing ones to the clear address. A second, independent pair of rising and falling masks picks the edges that may wake the system. Each pin also has a sleep-control bit: a 0 allows that pin to wake, and a 1 blocks it. A qualifying edge produces a one-cycle registered pulse on the wake output.

A simple register interface configures and reads the block. It has a write strobe, an address and write data, and a combinational read of the addressed register.

Top module: `gew_top`

## Requirements
- R1: After reset, every mask register, the sleep-control register and the status register read 0, and `irq_o` and `wake_o` are low.
- R2: Writing with `reg_wr_i` high stores `reg_wdata_i` at the next clock edge, and `reg_rdata_o` returns the stored value. The address map is 0 rising-interrupt mask, 1 falling-interrupt mask, 2 rising-wake mask, 3 falling-wake mask, 4 sleep control, 5 status (read only), and 6 clear (write only, reads 0).
- R3: A rising edge on pin n with bit n of the rising-interrupt mask set sets status bit n. A rising edge with only the falling mask set leaves that bit unchanged.
- R4: A falling edge on pin n with bit n of the falling-interrupt mask set sets status bit n. With both masks set, either edge sets the bit.
- R5: Status bits are sticky. Writing to the clear address resets each status bit whose write-data bit is 1, and status bits whose write-data bit is 0 keep their value.
- R6: If an enabled edge and a clear of the same status bit fall on the same clock edge, the bit ends up set.
- R7: `irq_o` is high exactly when at least one status bit is set.
- R8: `wake_o` is high for one cycle when any pin has an edge that its wake mask enables (rising or falling) and its sleep-control bit is 0. A sleep-control bit of 1 blocks wake for that pin. The wake path does not depend on the interrupt masks.
- R9: A pin change that is stable before clock edge k shows up in the status register and on `wake_o` just after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | 32 | Asynchronous pin inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Combined interrupt: OR of the status bits |
| wake_o | output | 1 | One-cycle wake request pulse |

## Verification
The assertions assume that the status register only loses a bit through a clear write, and that a new bit needs an enabled edge. For that reason they take the clear mask and the edge hits one cycle late, as the register sees them. They also assume each pin is held for at least one clock so that the synchroniser sees a clean sample. The stimulus changes pins only at the falling clock edge and holds them for several cycles before the next change. Register writes are driven at the falling edge with a single-cycle strobe, so no write is ever interleaved with a read sample.

// File: rtl/gew_pkg.sv
package gew_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_RISE_IRQ  = 3'd0,
    A_FALL_IRQ  = 3'd1,
    A_RISE_WAKE = 3'd2,
    A_FALL_WAKE = 3'd3,
    A_SLEEP     = 3'd4,
    A_STATUS    = 3'd5,
    A_CLEAR     = 3'd6
  } reg_addr_e;

  localparam int NUM_CFG = 5;
endpackage

// File: rtl/gew_sync.sv
module gew_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = pins_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign cur_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gew_regs.sv
module gew_regs
  import gew_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      rise_irq_o,
  output logic [N-1:0]      fall_irq_o,
  output logic [N-1:0]      rise_wake_o,
  output logic [N-1:0]      fall_wake_o,
  output logic [N-1:0]      sleep_o,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      rdata_o
);
  logic [N-1:0] cfg_q [NUM_CFG];
  logic [N-1:0] cfg_d [NUM_CFG];

  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    logic wen;
    assign wen = wr_i && (addr_i == ADDR_W'(r));
    always_comb begin
      cfg_d[r] = cfg_q[r];
      if (wen) cfg_d[r] = wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) cfg_q[r] <= '0;
      else        cfg_q[r] <= cfg_d[r];
    end
  end

  assign rise_irq_o  = cfg_q[A_RISE_IRQ];
  assign fall_irq_o  = cfg_q[A_FALL_IRQ];
  assign rise_wake_o = cfg_q[A_RISE_WAKE];
  assign fall_wake_o = cfg_q[A_FALL_WAKE];
  assign sleep_o     = cfg_q[A_SLEEP];
  assign clr_o       = (wr_i && addr_i == A_CLEAR) ? wdata_i : '0;

  always_comb begin
    unique case (addr_i)
      A_RISE_IRQ, A_FALL_IRQ, A_RISE_WAKE, A_FALL_WAKE, A_SLEEP:
        rdata_o = cfg_q[addr_i];
      A_STATUS: rdata_o = status_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gew_events.sv
module gew_events #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] rise_irq_i,
  input  logic [N-1:0] fall_irq_i,
  input  logic [N-1:0] rise_wake_i,
  input  logic [N-1:0] fall_wake_i,
  input  logic [N-1:0] sleep_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [N-1:0] rise, fall, irq_hits, wake_hits;
  logic [N-1:0] status_d, status_q;
  logic         wake_d, wake_q;

  always_comb begin
    rise      = cur_i & ~prev_i;
    fall      = ~cur_i & prev_i;
    irq_hits  = (rise & rise_irq_i) | (fall & fall_irq_i);
    wake_hits = ((rise & rise_wake_i) | (fall & fall_wake_i)) & ~sleep_i;
    status_d  = (status_q & ~clr_i) | irq_hits;
    wake_d    = |wake_hits;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      wake_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      wake_q   <= wake_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;
  assign wake_o   = wake_q;

  assert_status_needs_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) & ~$past(rise_irq_i | fall_irq_i)) == '0);

  assert_status_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(status_q & ~clr_i) & ~status_q) == '0);

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(irq_hits) & ~status_q) == '0);

  assert_irq_drop_needs_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq_o) |-> ($past(clr_i) != '0));

  assert_wake_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_o |-> ($past(~sleep_i & (rise_wake_i | fall_wake_i)) != '0));
endmodule

// File: rtl/gew_top.sv
module gew_top
  import gew_pkg::*;
#(
  parameter int N           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      pins_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N-1:0]      reg_wdata_i,
  output logic [N-1:0]      reg_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [1:0]   rst_sync_q;
  logic         rst_n;
  logic [N-1:0] cur, prev, status;
  logic [N-1:0] rise_irq, fall_irq, rise_wake, fall_wake, sleep, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  gew_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_n(rst_n), .pins_i(pins_i), .cur_o(cur), .prev_o(prev)
  );

  gew_regs #(.N(N)) u_regs (
    .clk_i(clk_i), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .status_i(status),
    .rise_irq_o(rise_irq), .fall_irq_o(fall_irq),
    .rise_wake_o(rise_wake), .fall_wake_o(fall_wake),
    .sleep_o(sleep), .clr_o(clr), .rdata_o(reg_rdata_o)
  );

  gew_events #(.N(N)) u_events (
    .clk_i(clk_i), .rst_n(rst_n), .cur_i(cur), .prev_i(prev),
    .rise_irq_i(rise_irq), .fall_irq_i(fall_irq),
    .rise_wake_i(rise_wake), .fall_wake_i(fall_wake),
    .sleep_i(sleep), .clr_i(clr),
    .status_o(status), .irq_o(irq_o), .wake_o(wake_o)
  );
endmodule

// File: tb/test_gew_top.sv
module test_gew_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pins = '0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_cfg [5];
  logic [31:0] m_status = '0;

  always #4 clk = ~clk;

  gew_top i_gew_top (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (a < 3'd5) m_cfg[a] = d;
    if (a == 3'd6) m_status = m_status & ~d;
  endtask

  // change pins; optionally clear on the same edge that latches the new event
  task automatic step(input logic [31:0] np, input logic [31:0] clr_same);
    logic [31:0] rise, fall, hits, v;
    logic exp_wake;
    @(negedge clk);
    rise = np & ~pins;
    fall = ~np & pins;
    pins = np;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (clr_same != 0) begin wr = 1'b1; addr = 3'd6; wdata = clr_same; end
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    hits = (rise & m_cfg[0]) | (fall & m_cfg[1]);
    m_status = (m_status & ~clr_same) | hits;
    exp_wake = |(((rise & m_cfg[2]) | (fall & m_cfg[3])) & ~m_cfg[4]);
    rd(3'd5, v);
    check("R3/R4/R6/R9 status", v, m_status);
    check("R7 irq", {31'd0, irq}, {31'd0, |m_status});
    check("R8/R9 wake", {31'd0, wake}, {31'd0, exp_wake});
    @(negedge clk);
    check("R8 wake one cycle", {31'd0, wake}, 32'd0);
  endtask

  task automatic clear_only(input logic [31:0] m);
    logic [31:0] v;
    wr_reg(3'd6, m);
    rd(3'd5, v);
    check("R5 clear", v, m_status);
    check("R7 irq after clear", {31'd0, irq}, {31'd0, |m_status});
  endtask

  initial begin
    #1600000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 5; i++) m_cfg[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], v);
      check("R1 reset reg", v, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 wake", {31'd0, wake}, 32'd0);

    // R2 register access
    for (int a = 0; a < 5; a++) begin
      wr_reg(a[2:0], $urandom);
    end
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v);
      check("R2 readback", v, m_cfg[a]);
    end
    rd(3'd6, v);
    check("R2 clear reads zero", v, 32'd0);
    clear_only(32'hFFFF_FFFF);

    // directed: R3 rise-only, R4 fall and both
    wr_reg(3'd0, 32'h0000_0005);
    wr_reg(3'd1, 32'h0000_0006);
    wr_reg(3'd2, 32'h0);
    wr_reg(3'd3, 32'h0);
    wr_reg(3'd4, 32'h0);
    step(32'h0000_000F, 0);  // rises on 0..3: bits 0,2 set
    step(32'h0000_0000, 0);  // falls on 0..3: bits 1,2
    clear_only(32'h0000_0001); // R5 partial clear
    clear_only(32'h0);         // R5 zero has no effect
    clear_only(32'hFFFF_FFFF);
    // R6 set wins over same-edge clear
    step(32'h0000_0001, 32'h0000_0001);
    clear_only(32'hFFFF_FFFF);

    // R8 sleep gating and independence from interrupt masks
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd2, 32'hFFFF_FFFF);
    wr_reg(3'd3, 32'hFFFF_FFFF);
    wr_reg(3'd4, 32'hFFFF_FFFF);
    step(32'h0000_0100, 0);   // blocked by sleep
    wr_reg(3'd4, 32'hFFFF_FEFF);
    step(32'h0000_0000, 0);   // falling on pin 8 wakes
    wr_reg(3'd4, 32'h0);
    wr_reg(3'd3, 32'h0);
    step(32'h8000_0000, 0);   // rise wake on pin 31
    step(32'h0000_0000, 0);   // fall not enabled: no wake

    // constrained random
    for (int it = 0; it < 300; it++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) wr_reg($urandom_range(0, 4), $urandom);
      else if (sel == 1) clear_only($urandom);
      else if (sel == 2) step($urandom, $urandom);
      else step(pins ^ (32'd1 << $urandom_range(0, 31)), 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule